// File: doc/BRIEF.md
# Rewindable FIFO with Half-Full Flag

This block is a single-clock first-in, first-out queue with internal storage, nine bits per word by default and a power-of-two depth. A producer raises `wr_req` for one cycle to store the word on `wr_data`, and a consumer raises `rd_req` for one cycle to fetch the oldest word. The fetched word appears on `rd_data` with `rd_valid` high in the cycle after the accepting clock edge. Three active-low status outputs report empty, full and "more than half full".

A rewind request sends the read side back to storage location zero while the write side is left alone. Everything written since reset can then be read again, for example to resend a packet after an error. Rewind is honoured only while `link_mode` is low, and only in a cycle with no read or write request.

Requests that arrive at the wrong moment are kept rather than lost. A read asked for while the queue is empty is parked, and the next word written goes straight to the output. A write asked for while the queue is full is parked, and that word is stored at the next read.

Top module: `rewind_fifo`

## Requirements
- R1: While `rst_n` is low and in the cycle after it is released: `empty_n` = 0, `full_n` = 1, `half_n` = 1, `rd_valid` = 0, and both read and write positions are location zero.
- R2: Accepted words come out in the order they were written, with all nine bits intact (0x1FF and 0x100 included). A read accepted at edge k gives `rd_valid` = 1 and the word on `rd_data` after edge k. In any cycle with no read delivered, `rd_valid` = 0.
- R3: A write request while `full_n` = 0 changes neither the stored words nor the flags nor the write position at that edge.
- R4: A read request while `empty_n` = 0 delivers no word (`rd_valid` stays 0), leaves the read position unchanged, and keeps `empty_n` = 0.
- R5: With N = writes minus reads since the last reset or rewind, `full_n` is 0 exactly when N equals DEPTH, and `empty_n` is 0 exactly when N is 0.
- R6: `half_n` goes low on the write that raises N from DEPTH/2 to DEPTH/2+1. It stays low until a read brings N back to exactly DEPTH/2, and it is high whenever N ≤ DEPTH/2.
- R7: `rewind_req` = 1 with `link_mode` = 0 and no read or write request sets the read position to location zero and keeps the write position. The flags then follow N = total writes since reset, and later reads replay the words from the first one written after reset.
- R8: `rewind_req` has no effect when `link_mode` = 1, or when `rd_req` or `wr_req` is high in the same cycle. In the second case the coincident read or write proceeds normally.
- R9: After a read request is made while empty, the next accepted write puts its own word on `rd_data` with `rd_valid` = 1 in the following cycle, with no further read request. N stays 0.
- R10: After a write request is made while full, that word is stored at the next accepted read edge, so `full_n` stays 0. The parked word is read out after all words that were stored before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_req | input | 1 | One-cycle write request |
| wr_data | input | WIDTH | Word to be stored |
| rd_req | input | 1 | One-cycle read request |
| rewind_req | input | 1 | Request to return the read side to location zero |
| link_mode | input | 1 | High when the block is part of a chain; rewind is disabled |
| rd_data | output | WIDTH | Last word delivered |
| rd_valid | output | 1 | High for one cycle when `rd_data` holds a newly delivered word |
| empty_n | output | 1 | Low when no word is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
The assertions assume that a rewind is requested only after fewer than DEPTH writes since reset. If more writes have been made, the pointer difference after the rewind wraps and the flags lose meaning. The bench resets before every rewind scenario and writes at most six words before rewinding. The assertions also assume that `link_mode` does not change while a rewind is pending, and the stimulus moves it only in a dedicated idle cycle. Every input is driven on the falling clock edge, so each request is one clean cycle.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

  // Words held: write position minus read position, kept to PW bits.
  function automatic int unsigned occupancy(input int unsigned wp,
                                            input int unsigned rp,
                                            input int unsigned pw);
    return (wp - rp) & ((32'd1 << pw) - 32'd1);
  endfunction

  // True once strictly more than half of the depth is in use.
  function automatic logic beyond_half(input int unsigned fill,
                                       input int unsigned depth);
    return fill > (depth / 2);
  endfunction

  // Per-cycle transfer decisions of the control unit.
  typedef struct packed {
    logic rd_go;    // read request accepted directly
    logic wr_go;    // write request accepted directly
    logic auto_rd;  // parked read completed by this write
    logic auto_wr;  // parked write completed by this read
    logic rewind;   // read side returns to location zero
  } xfer_t;

endpackage

// File: rtl/rwf_flags.sv
module rwf_flags #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] wp,
  input  logic [PW-1:0] rp,
  output logic          is_empty,
  output logic          is_full,
  output logic          is_over_half
);
  logic [PW-1:0] fill;

  always_comb begin
    fill         = PW'(rwf_pkg::occupancy(32'(wp), 32'(rp), PW));
    is_empty     = (fill == '0);
    is_full      = (fill == PW'(DEPTH));
    is_over_half = rwf_pkg::beyond_half(32'(fill), DEPTH);
  end

  // R5: the pointer difference never exceeds the depth
  a_r5_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill) <= DEPTH);

endmodule

// File: rtl/rwf_ctrl.sv
module rwf_ctrl #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4,
  parameter int unsigned PW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_req,
  input  logic             rewind_req,
  input  logic             link_mode,
  input  logic             is_empty,
  input  logic             is_full,
  output logic [PW-1:0]    wp,
  output logic [PW-1:0]    rp,
  output logic             mem_we,
  output logic [AW-1:0]    mem_waddr,
  output logic [WIDTH-1:0] mem_wdata,
  output logic [AW-1:0]    mem_raddr,
  output logic             rd_fetch,
  output logic             rd_bypass
);
  import rwf_pkg::*;

  xfer_t            ev;
  logic [PW-1:0]    wp_q, rp_q;
  logic             rpark_q, wpark_q;
  logic [WIDTH-1:0] wpword_q;
  logic             rd_adv;

  always_comb begin
    ev.rd_go   = rd_req & ~is_empty;
    ev.wr_go   = wr_req & ~is_full;
    ev.auto_rd = rpark_q & ev.wr_go;
    ev.auto_wr = wpark_q & ev.rd_go;
    ev.rewind  = rewind_req & ~link_mode & ~rd_req & ~wr_req;
    mem_we     = ev.wr_go | ev.auto_wr;
    rd_adv     = ev.rd_go | ev.auto_rd;
    mem_wdata  = ev.wr_go ? wr_data : wpword_q;
    mem_waddr  = wp_q[AW-1:0];
    mem_raddr  = rp_q[AW-1:0];
    rd_fetch   = ev.rd_go;
    rd_bypass  = ev.auto_rd;
  end

  assign wp = wp_q;
  assign rp = rp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q     <= '0;
      rp_q     <= '0;
      rpark_q  <= 1'b0;
      wpark_q  <= 1'b0;
      wpword_q <= '0;
    end else begin
      if (mem_we) wp_q <= wp_q + PW'(1);
      if (ev.rewind)  rp_q <= '0;
      else if (rd_adv) rp_q <= rp_q + PW'(1);

      if (ev.rewind)              rpark_q <= 1'b0;
      else if (ev.auto_rd)        rpark_q <= rd_req;
      else if (rd_req && is_empty) rpark_q <= 1'b1;

      if (ev.rewind) begin
        wpark_q <= 1'b0;
      end else if (ev.auto_wr) begin
        wpark_q <= wr_req;
        if (wr_req) wpword_q <= wr_data;
      end else if (wr_req && is_full) begin
        wpark_q  <= 1'b1;
        wpword_q <= wr_data;
      end
    end
  end

  // R3: while full and nothing is read, the write side stays put
  a_r3_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && !rd_req) |=> $stable(wp_q));

  // R4: while empty and nothing is written, the read side stays put
  a_r4_empty_holds_read: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && !wr_req && !rewind_req) |=> $stable(rp_q));

  // R7: an honoured rewind returns to zero and keeps the write side
  a_r7_rewind_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind_req && !link_mode && !rd_req && !wr_req) |=> (rp_q == '0 && $stable(wp_q)));

  // R8: rewind in chain mode leaves the read side alone
  a_r8_rewind_in_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind_req && link_mode && !rd_req && !wr_req) |=> $stable(rp_q));

  // R10: a parked write lands on the next accepted read
  a_r10_parked_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wpark_q && rd_req && !is_empty) |=> (wp_q == $past(wp_q) + PW'(1)));

endmodule

// File: rtl/rwf_store.sv
module rwf_store #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             fetch,
  input  logic [AW-1:0]    raddr,
  input  logic             bypass,
  input  logic [WIDTH-1:0] byp_data,
  output logic [WIDTH-1:0] q,
  output logic             q_valid
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q       <= '0;
      q_valid <= 1'b0;
    end else if (fetch) begin
      q       <= cells[raddr];
      q_valid <= 1'b1;
    end else if (bypass) begin
      q       <= byp_data;
      q_valid <= 1'b1;
    end else begin
      q_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_req,
  input  logic             rewind_req,
  input  logic             link_mode,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0]    wp, rp;
  logic             is_empty, is_full, is_over_half;
  logic             mem_we, rd_fetch, rd_bypass;
  logic [AW-1:0]    mem_waddr, mem_raddr;
  logic [WIDTH-1:0] mem_wdata;

  rwf_flags #(.DEPTH(DEPTH), .PW(PW)) u_flags (
    .clk(clk), .rst_n(rst_n), .wp(wp), .rp(rp),
    .is_empty(is_empty), .is_full(is_full), .is_over_half(is_over_half)
  );

  rwf_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
    .rd_req(rd_req), .rewind_req(rewind_req), .link_mode(link_mode),
    .is_empty(is_empty), .is_full(is_full), .wp(wp), .rp(rp),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr), .rd_fetch(rd_fetch), .rd_bypass(rd_bypass)
  );

  rwf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
    .wdata(mem_wdata), .fetch(rd_fetch), .raddr(mem_raddr),
    .bypass(rd_bypass), .byp_data(wr_data), .q(rd_data), .q_valid(rd_valid)
  );

  assign empty_n = ~is_empty;
  assign full_n  = ~is_full;
  assign half_n  = ~is_over_half;

  // R9: a completed parked read shows the word written at that edge
  a_r9_auto_read_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bypass |=> (rd_valid && rd_data == $past(wr_data)));

  // R6: half-full is only reported when not empty
  a_r6_half_implies_data: assert property (@(posedge clk) disable iff (!rst_n)
    !half_n |-> empty_n);

endmodule

// File: tb/rewind_fifo_test.sv
module rewind_fifo_test;
  localparam int W = 9;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0, rd_req = 1'b0, rewind_req = 1'b0, link_mode = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic rd_valid, empty_n, full_n, half_n;

  always #4 clk = ~clk;

  rewind_fifo #(.WIDTH(W), .DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
    .rd_req(rd_req), .rewind_req(rewind_req), .link_mode(link_mode),
    .rd_data(rd_data), .rd_valid(rd_valid), .empty_n(empty_n),
    .full_n(full_n), .half_n(half_n)
  );

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";

  // Reference model: every word written since reset, plus a read index.
  logic [W-1:0] hist[$];
  int ri = 0;
  bit rpark = 0, wpark = 0;
  logic [W-1:0] wpword = '0;
  logic [W-1:0] sb_q[$];
  bit exp_v = 0;
  bit mon_on = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  function automatic int held();
    return hist.size() - ri;
  endfunction

  // Driver: applies one cycle of stimulus and advances the model.
  task automatic step(input bit w, input logic [W-1:0] d, input bit r,
                      input bit t, input bit ch);
    int cnt;
    bit emp, ful, rt_ok, rdok, wrok, a_r, a_w;
    @(negedge clk);
    wr_req = w; wr_data = d; rd_req = r; rewind_req = t; link_mode = ch;
    cnt = held(); emp = (cnt == 0); ful = (cnt == D);
    rt_ok = t && !ch && !w && !r;
    rdok = r && !emp; wrok = w && !ful;
    a_r = rpark && wrok; a_w = wpark && rdok;
    exp_v = 0;
    if (rdok) begin sb_q.push_back(hist[ri]); ri++; exp_v = 1; end
    if (a_w) hist.push_back(wpword);
    if (wrok) hist.push_back(d);
    if (a_r) begin sb_q.push_back(d); ri++; exp_v = 1; end
    if (rt_ok) ri = 0;
    if (rt_ok) rpark = 0;
    else if (a_r) rpark = r;
    else if (r && emp) rpark = 1;
    if (rt_ok) wpark = 0;
    else if (a_w) begin wpark = w; if (w) wpword = d; end
    else if (w && ful) begin wpark = 1; wpword = d; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0);
  endtask

  // Monitor: scoreboard pop and flag comparison after each edge.
  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      int cnt;
      cnt = held();
      chk(empty_n == (cnt != 0), tag, "empty_n", empty_n, cnt != 0);
      chk(full_n == (cnt != D), tag, "full_n", full_n, cnt != D);
      chk(half_n == !(cnt > D/2), tag, "half_n", half_n, !(cnt > D/2));
      chk(rd_valid == exp_v, tag, "rd_valid", rd_valid, exp_v);
      if (rd_valid && exp_v && sb_q.size() > 0) begin
        logic [W-1:0] e;
        e = sb_q.pop_front();
        chk(rd_data == e, tag, "rd_data", rd_data, e);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    mon_on = 0;
    rst_n = 0; wr_req = 0; rd_req = 0; rewind_req = 0; link_mode = 0;
    hist.delete(); sb_q.delete(); ri = 0; rpark = 0; wpark = 0; exp_v = 0;
    repeat (3) @(posedge clk);
    #2;
    chk(empty_n == 0 && full_n == 1 && half_n == 1, "R1", "flags in reset",
        {empty_n, full_n, half_n}, 3'b011);
    chk(rd_valid == 0, "R1", "rd_valid in reset", rd_valid, 0);
    @(negedge clk);
    rst_n = 1;
    mon_on = 1;
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tag = "R1";
    do_reset();
    idle(1);

    // R4: read on empty delivers nothing; R9: next write is bypassed out
    tag = "R4";
    step(0, '0, 1, 0, 0);
    idle(2);
    tag = "R9";
    step(1, 9'h1A5, 0, 0, 0);
    idle(2);

    // R2: order and full width, including simultaneous read and write
    tag = "R2";
    step(1, 9'h1FF, 0, 0, 0);
    step(1, 9'h100, 0, 0, 0);
    step(1, 9'h0AA, 1, 0, 0);
    step(1, 9'h155, 1, 0, 0);
    step(1, 9'h001, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, '0, 1, 0, 0);
    idle(2);

    // R6: half-full threshold at DEPTH/2
    tag = "R6";
    for (int i = 0; i < D/2; i++) step(1, 9'(i + 32), 0, 0, 0);
    idle(1);
    step(1, 9'h0C0, 0, 0, 0);
    idle(1);
    step(0, '0, 1, 0, 0);
    idle(1);
    step(1, 9'h0C1, 0, 0, 0);

    // R5: fill to DEPTH
    tag = "R5";
    while (held() < D) step(1, 9'(held() + 64), 0, 0, 0);
    idle(2);

    // R3: write while full changes nothing now; R10: parked word lands
    tag = "R3";
    step(1, 9'h0EE, 0, 0, 0);
    idle(2);
    tag = "R10";
    step(0, '0, 1, 0, 0);
    idle(1);
    while (held() > 0) step(0, '0, 1, 0, 0);
    idle(2);
    chk(sb_q.size() == 0, "R10", "scoreboard drained", sb_q.size(), 0);

    // R7: rewind replays from the first word
    tag = "R7";
    do_reset();
    for (int i = 0; i < 6; i++) step(1, 9'(9'h010 + i), 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, '0, 1, 0, 0);
    idle(1);
    step(0, '0, 0, 1, 0);
    idle(1);
    for (int i = 0; i < 2; i++) step(0, '0, 1, 0, 0);

    // R8: rewind ignored in chain mode and when traffic coincides
    tag = "R8";
    step(0, '0, 0, 0, 1);
    step(0, '0, 0, 1, 1);
    step(0, '0, 0, 0, 0);
    step(0, '0, 1, 0, 0);
    step(0, '0, 1, 1, 0);
    step(1, 9'h077, 0, 1, 0);
    idle(1);
    while (held() > 0) step(0, '0, 1, 0, 0);
    idle(2);
    chk(sb_q.size() == 0, "R8", "scoreboard drained", sb_q.size(), 0);

    mon_on = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule